// File: doc/BRIEF.md
# Guarded Stream Process Wrapper

This block sequences a fixed-function compute core that implements one process of a streaming dataflow network. It walks a two-level loop nest with an outer iterator `j` and an inner iterator `i`. For every point of the nest it runs four phases in a fixed order: it evaluates guards, reads one operand, runs the core, and writes the result. Each phase waits only on its own local FIFO flags. No external scheduler is involved, and no other process is consulted.

Guards are affine expressions of the form `ci*i + cj*j + c0`. They are compared either against zero with `>= 0` or for equality with `== 0`. The coefficients are parameters that stay fixed while the block runs. One guard picks which of the two input FIFOs feeds the core in the current iteration. Each output FIFO has its own guard, so a single result may go to one output, several outputs, or none.

The FIFOs are first-word-fall-through. Read data is valid while the empty flag is low, and a read strobe pops that word. A write strobe pushes `outData` into every output that is strobed in that cycle. The core is driven by a one-cycle start pulse and answers with a one-cycle done pulse.

Top module: `spw_top`

## Requirements
- R1: While reset is held, `inRead`, `outWrite` and `coreStart` are all zero and `allDone` is low.
- R2: Iterations follow the order `i` from I_LO to I_HI inside `j` from J_LO to J_HI. `i` wraps to I_LO and carries into `j`. The core is started exactly once per iteration, in this order.
- R3: In each iteration, input port 1 is read when the select guard holds and input port 0 otherwise. At most one read strobe is high in any cycle.
- R4: A read waits while the selected input FIFO is empty. No core start happens until that read has completed, and a read is followed by `coreStart` in the next cycle.
- R5: `coreStart` is a single-cycle pulse. `coreOperand` holds its value from the start until `coreDone`.
- R6: An output port receives the result of an iteration exactly when its guard holds. `>=` guards and `==` guards are both supported, and several ports may be written in the same iteration.
- R7: A guarded write waits while its output FIFO is full. An output whose guard is false is skipped without regard to its full flag. Ports that are not full are written even while another guarded port is stalled.
- R8: After the last iteration `allDone` rises and stays high, and no further reads, writes or core starts occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inEmpty | input | 2 | Empty flags of the two input FIFOs |
| inDataFlat | input | 2*DATA_W | Head words of the input FIFOs, port 0 in the low bits |
| inRead | output | 2 | Pop strobes of the input FIFOs |
| outFull | input | NUM_OUT | Full flags of the output FIFOs |
| outWrite | output | NUM_OUT | Push strobes of the output FIFOs |
| outData | output | DATA_W | Result word presented to all outputs |
| coreStart | output | 1 | One-cycle start pulse to the core |
| coreOperand | output | DATA_W | Operand held for the core |
| coreDone | input | 1 | One-cycle completion pulse from the core |
| coreResult | input | DATA_W | Core result, valid with coreDone |
| allDone | output | 1 | High once the whole loop nest is finished |

## Verification
The assertions check several properties on every cycle:
- at most one input is popped at a time;
- each read leads directly to a one-cycle start pulse;
- the operand holds still while the core is busy;
- the iterators stay inside their bounds;
- the block stays quiet once finished.

Other behaviours appear only in the bench's staged scenarios:
- which input feeds each iteration, and in what order;
- which outputs receive each result under the mix of `>=` and `==` guards;
- that an unguarded output held full never stalls the loop, while a guarded full one does.

// File: rtl/spw_pkg.sv
package spw_pkg;

  typedef struct packed {
    logic loadOperand;
    logic loadResult;
    logic busy;
    logic inSel;
  } spw_strobe_t;

  typedef enum logic [2:0] {
    ST_CTRL,
    ST_READ,
    ST_START,
    ST_WAIT,
    ST_WRITE,
    ST_DONE
  } spw_state_e;

  function automatic logic guardHolds(input logic signed [31:0] iv,
                                      input logic signed [31:0] jv,
                                      input int ci, input int cj, input int c0,
                                      input bit isEq);
    logic signed [31:0] acc;
    acc = ci * iv + cj * jv + c0;
    return isEq ? (acc == 0) : (acc >= 0);
  endfunction

endpackage

// File: rtl/spw_ctrl.sv
module spw_ctrl
  import spw_pkg::*;
#(
  parameter int ITER_W  = 8,
  parameter int NUM_OUT = 2,
  parameter int I_LO = 0,
  parameter int I_HI = 3,
  parameter int J_LO = 0,
  parameter int J_HI = 2,
  parameter int SEL_CI = 1,
  parameter int SEL_CJ = 0,
  parameter int SEL_C0 = -2,
  parameter bit SEL_EQ = 1'b0,
  parameter int OUT_CI [NUM_OUT] = '{-1, 1},
  parameter int OUT_CJ [NUM_OUT] = '{0, -1},
  parameter int OUT_C0 [NUM_OUT] = '{2, -1},
  parameter bit OUT_EQ [NUM_OUT] = '{1'b0, 1'b1}
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         inEmpty,
  output logic [1:0]         inRead,
  input  logic [NUM_OUT-1:0] outFull,
  output logic [NUM_OUT-1:0] outWrite,
  output logic               coreStart,
  input  logic               coreDone,
  output logic               allDone,
  output spw_strobe_t        strobe
);

  localparam logic signed [ITER_W-1:0] I_LO_V = ITER_W'(I_LO);
  localparam logic signed [ITER_W-1:0] I_HI_V = ITER_W'(I_HI);
  localparam logic signed [ITER_W-1:0] J_LO_V = ITER_W'(J_LO);
  localparam logic signed [ITER_W-1:0] J_HI_V = ITER_W'(J_HI);

  spw_state_e state;
  logic signed [ITER_W-1:0] iQ, jQ;
  logic signed [31:0] iWide, jWide;
  logic selGuard, selQ;
  logic [NUM_OUT-1:0] outGuard, pendingQ, blockedNow;
  logic lastIter, readOk;

  assign iWide = 32'(iQ);
  assign jWide = 32'(jQ);
  assign selGuard = guardHolds(iWide, jWide, SEL_CI, SEL_CJ, SEL_C0, SEL_EQ);

  for (genvar k = 0; k < NUM_OUT; k++) begin : g_outGuard
    assign outGuard[k] = guardHolds(iWide, jWide, OUT_CI[k], OUT_CJ[k], OUT_C0[k], OUT_EQ[k]);
  end

  assign lastIter   = (iQ == I_HI_V) && (jQ == J_HI_V);
  assign readOk     = (state == ST_READ) && !inEmpty[selQ];
  assign blockedNow = pendingQ & outFull;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_CTRL;
      iQ       <= I_LO_V;
      jQ       <= J_LO_V;
      selQ     <= 1'b0;
      pendingQ <= '0;
    end else begin
      case (state)
        ST_CTRL: begin
          selQ  <= selGuard;
          state <= ST_READ;
        end
        ST_READ: begin
          if (readOk) state <= ST_START;
        end
        ST_START: state <= ST_WAIT;
        ST_WAIT: begin
          if (coreDone) begin
            pendingQ <= outGuard;
            state    <= ST_WRITE;
          end
        end
        ST_WRITE: begin
          pendingQ <= blockedNow;
          if (blockedNow == '0) begin
            if (lastIter) begin
              state <= ST_DONE;
            end else begin
              state <= ST_CTRL;
              if (iQ == I_HI_V) begin
                iQ <= I_LO_V;
                jQ <= jQ + 1'b1;
              end else begin
                iQ <= iQ + 1'b1;
              end
            end
          end
        end
        default: state <= ST_DONE;
      endcase
    end
  end

  always_comb begin
    inRead = 2'b00;
    if (readOk) inRead[selQ] = 1'b1;
  end

  assign outWrite  = (state == ST_WRITE) ? (pendingQ & ~outFull) : '0;
  assign coreStart = (state == ST_START);
  assign allDone   = (state == ST_DONE);

  assign strobe.loadOperand = readOk;
  assign strobe.loadResult  = (state == ST_WAIT) && coreDone;
  assign strobe.busy        = (state == ST_START) || (state == ST_WAIT);
  assign strobe.inSel       = selQ;

  // R2
  iter_range_chk: assert property (@(posedge clk) disable iff (rst)
    (iQ >= I_LO_V) && (iQ <= I_HI_V) && (jQ >= J_LO_V) && (jQ <= J_HI_V));

  // R3
  read_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(inRead));

  // R4
  read_to_start_chk: assert property (@(posedge clk) disable iff (rst)
    (inRead != 2'b00) |=> coreStart);

  // R5
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    coreStart |=> !coreStart);

  // R8
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    allDone |=> (allDone && inRead == 2'b00 && outWrite == '0 && !coreStart));

endmodule

// File: rtl/spw_dp.sv
module spw_dp
  import spw_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  spw_strobe_t         strobe,
  input  logic [2*DATA_W-1:0] inDataFlat,
  output logic [DATA_W-1:0]   coreOperand,
  input  logic [DATA_W-1:0]   coreResult,
  output logic [DATA_W-1:0]   outData
);

  localparam int NUM_IN = 2;

  logic [DATA_W-1:0] inWord [NUM_IN];
  logic [DATA_W-1:0] operandQ, resultQ;

  for (genvar p = 0; p < NUM_IN; p++) begin : g_inWord
    assign inWord[p] = inDataFlat[p*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      operandQ <= '0;
      resultQ  <= '0;
    end else begin
      if (strobe.loadOperand) operandQ <= inWord[strobe.inSel];
      if (strobe.loadResult)  resultQ  <= coreResult;
    end
  end

  assign coreOperand = operandQ;
  assign outData     = resultQ;

  // R5
  operand_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe.busy && $past(strobe.busy)) |-> $stable(coreOperand));

endmodule

// File: rtl/spw_top.sv
module spw_top
  import spw_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ITER_W  = 8,
  parameter int NUM_OUT = 2,
  parameter int I_LO = 0,
  parameter int I_HI = 3,
  parameter int J_LO = 0,
  parameter int J_HI = 2,
  parameter int SEL_CI = 1,
  parameter int SEL_CJ = 0,
  parameter int SEL_C0 = -2,
  parameter bit SEL_EQ = 1'b0,
  parameter int OUT_CI [NUM_OUT] = '{-1, 1},
  parameter int OUT_CJ [NUM_OUT] = '{0, -1},
  parameter int OUT_C0 [NUM_OUT] = '{2, -1},
  parameter bit OUT_EQ [NUM_OUT] = '{1'b0, 1'b1}
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          inEmpty,
  input  logic [2*DATA_W-1:0] inDataFlat,
  output logic [1:0]          inRead,
  input  logic [NUM_OUT-1:0]  outFull,
  output logic [NUM_OUT-1:0]  outWrite,
  output logic [DATA_W-1:0]   outData,
  output logic                coreStart,
  output logic [DATA_W-1:0]   coreOperand,
  input  logic                coreDone,
  input  logic [DATA_W-1:0]   coreResult,
  output logic                allDone
);

  spw_strobe_t strobe;

  spw_ctrl #(
    .ITER_W(ITER_W), .NUM_OUT(NUM_OUT),
    .I_LO(I_LO), .I_HI(I_HI), .J_LO(J_LO), .J_HI(J_HI),
    .SEL_CI(SEL_CI), .SEL_CJ(SEL_CJ), .SEL_C0(SEL_C0), .SEL_EQ(SEL_EQ),
    .OUT_CI(OUT_CI), .OUT_CJ(OUT_CJ), .OUT_C0(OUT_C0), .OUT_EQ(OUT_EQ)
  ) ctrl_i (
    .clk(clk), .rst(rst),
    .inEmpty(inEmpty), .inRead(inRead),
    .outFull(outFull), .outWrite(outWrite),
    .coreStart(coreStart), .coreDone(coreDone),
    .allDone(allDone), .strobe(strobe)
  );

  spw_dp #(.DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .strobe(strobe),
    .inDataFlat(inDataFlat),
    .coreOperand(coreOperand), .coreResult(coreResult),
    .outData(outData)
  );

endmodule

// File: tb/spw_top_tb_top.sv
`timescale 1ns/1ps
module spw_top_tb_top;

  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [1:0]    inEmpty, inRead, outFull, outWrite;
  logic [2*DW-1:0] inDataFlat;
  logic [DW-1:0] outData, coreOperand, coreResult;
  logic coreStart, coreDone, allDone;

  int in0Avail = 0, in1Avail = 0, in0Rd = 0, in1Rd = 0;
  int startCnt = 0, out0Cnt = 0, out1Cnt = 0;
  int opLog [16];
  int out0Log [16];
  int out1Log [16];
  logic full1Hold = 1'b1, randEn = 1'b0;
  logic [7:0] lfsr = 8'h5a;
  int coreCnt = 0;
  int checks = 0, errors = 0;
  bit finished = 0;

  assign inEmpty    = {in1Rd >= in1Avail, in0Rd >= in0Avail};
  assign inDataFlat = {8'(100 + in1Rd), 8'(10 + in0Rd)};
  assign outFull    = {full1Hold, randEn & lfsr[0]};
  assign coreDone   = (coreCnt == 1);
  assign coreResult = coreOperand * 8'd3 + 8'd1;

  always @(posedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    if (inRead[0]) in0Rd <= in0Rd + 1;
    if (inRead[1]) in1Rd <= in1Rd + 1;
    if (coreStart) begin
      if (startCnt < 16) opLog[startCnt] <= int'(coreOperand);
      startCnt <= startCnt + 1;
      coreCnt  <= 3;
    end else if (coreCnt > 0) coreCnt <= coreCnt - 1;
    if (outWrite[0]) begin
      if (out0Cnt < 16) out0Log[out0Cnt] <= int'(outData);
      out0Cnt <= out0Cnt + 1;
    end
    if (outWrite[1]) begin
      if (out1Cnt < 16) out1Log[out1Cnt] <= int'(outData);
      out1Cnt <= out1Cnt + 1;
    end
  end

  spw_top dut_i (
    .clk(clk), .rst(rst), .inEmpty(inEmpty), .inDataFlat(inDataFlat),
    .inRead(inRead), .outFull(outFull), .outWrite(outWrite), .outData(outData),
    .coreStart(coreStart), .coreOperand(coreOperand), .coreDone(coreDone),
    .coreResult(coreResult), .allDone(allDone)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int expOp [12];
    int exp0 [12];
    int exp1 [12];
    int n0 = 0, n1 = 0, c0 = 0, c1 = 0, k = 0, waitN = 0;
    int s0, s1, sw0, sw1;
    for (int j = 0; j <= 2; j++) begin
      for (int i = 0; i <= 3; i++) begin
        int op;
        if (i - 2 >= 0) begin op = 100 + c1; c1++; end
        else begin op = 10 + c0; c0++; end
        expOp[k] = op; k++;
        if (-i + 2 >= 0) begin exp0[n0] = (op * 3 + 1) % 256; n0++; end
        if (i - j - 1 == 0) begin exp1[n1] = (op * 3 + 1) % 256; n1++; end
      end
    end

    repeat (3) @(negedge clk);
    // R1 reset state
    check(inRead == 0, "R1 inRead", int'(inRead), 0);
    check(outWrite == 0, "R1 outWrite", int'(outWrite), 0);
    check(!coreStart && !allDone, "R1 start/done", int'(coreStart) + int'(allDone), 0);
    rst = 1'b0;

    repeat (30) @(negedge clk);
    // R4: both inputs empty, nothing may start
    check(startCnt == 0, "R4 empty input stalls", startCnt, 0);

    in0Avail = 6;
    repeat (40) @(negedge clk);
    // R7: out1 full but unguarded at (0,0) -> skipped; guarded at (0,1) -> stall
    check(out0Cnt == 2, "R7 out0 written past full out1", out0Cnt, 2);
    check(out1Cnt == 0, "R7 full out1 not written", out1Cnt, 0);
    check(startCnt == 2, "R7 loop stalled on guarded full", startCnt, 2);

    full1Hold = 1'b0;
    repeat (40) @(negedge clk);
    // R4: (0,2) selects empty input 1
    check(startCnt == 2, "R4 empty selected input stalls", startCnt, 2);
    check(out1Cnt == 1, "R6 out1 written after release", out1Cnt, 1);
    check(in0Rd == 2, "R3 only input 0 read so far", in0Rd, 2);

    in1Avail = 6;
    randEn = 1'b1;
    while (!allDone && waitN < 5000) begin @(negedge clk); waitN++; end
    check(allDone == 1'b1, "R8 done reached", int'(allDone), 1);
    check(startCnt == 12, "R2 one start per iteration", startCnt, 12);
    for (int q = 0; q < 12; q++)
      check(opLog[q] == expOp[q], "R2/R3 operand order", opLog[q], expOp[q]);
    check(out0Cnt == n0, "R6 out0 count", out0Cnt, n0);
    check(out1Cnt == n1, "R6 out1 count", out1Cnt, n1);
    for (int q = 0; q < n0; q++)
      check(out0Log[q] == exp0[q], "R6 out0 data", out0Log[q], exp0[q]);
    for (int q = 0; q < n1; q++)
      check(out1Log[q] == exp1[q], "R6 out1 data", out1Log[q], exp1[q]);

    s0 = in0Rd; s1 = in1Rd; sw0 = out0Cnt; sw1 = out1Cnt;
    in0Avail = 10; in1Avail = 10;
    repeat (20) @(negedge clk);
    // R8: quiet after done, even with input available
    check(in0Rd == s0 && in1Rd == s1, "R8 no reads after done", in0Rd + in1Rd, s0 + s1);
    check(out0Cnt == sw0 && out1Cnt == sw1, "R8 no writes after done", out0Cnt + out1Cnt, sw0 + sw1);
    check(startCnt == 12 && allDone, "R8 done sticky", startCnt, 12);
    check(in0Rd == 6 && in1Rd == 6, "R3 per-input read totals", in0Rd * 100 + in1Rd, 606);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule